// File: doc/BRIEF.md
# One-Shot Dual-Compare Output Channel

This block drives a single output pin from two one-shot compares against a free-running counter bus. Software writes a leading-edge match value and a trailing-edge match value. When the counter reaches the leading value, the pin moves to its leading level. When it reaches the trailing value, the pin moves to the opposite level. The result is one pulse, or one edge if only one compare is armed. Each compare fires once and then disarms. A counter wrap does not repeat the pulse until software rewrites the values.

The trailing value goes through a staging register. A write to the staging register only stores the value. The value is copied into the hidden compare register, and that compare is armed, when the leading value is written next, or when software sets an explicit commit strobe. This keeps a leading/trailing pair coherent. Every match sets a sticky status flag, which software clears by writing 1 to it. A polarity bit chooses which level counts as leading.

Top module: `oneshot_cmp_chan`

## Requirements
- R1: After a synchronous reset, the pin is low, both compares are disarmed, the flag and the polarity bit are 0, and address 0 reads 0.
- R2: Writing address 0 stores the leading value and arms the leading compare. If the counter bus equals that value at a clock edge while the compare is armed, the pin takes the leading level after that edge. The leading level is 1 when polarity is 0 and 0 when polarity is 1.
- R3: A match of the armed trailing compare drives the pin, after that edge, to the trailing level, which equals the polarity bit.
- R4: Each compare disarms on its first match. Later occurrences of the same counter value leave the pin unchanged until the compare is armed again. The armed bits read back at control bits 4 (leading) and 5 (trailing).
- R5: Writing address 1 only stores the staging value and sets the pending bit (control bit 7). The staged value is copied into the hidden trailing compare register, and that compare is armed, by the next address-0 write while pending is set, or by a control write with bit 2 set. Either transfer clears pending. A staging write made after that transfer does not change the armed trailing compare.
- R6: An address-0 write while pending is clear arms only the leading compare. The pin then makes one transition and holds that level through any number of counter wraps.
- R7: Control bit 0 is a flag that is set on every match. Writing 1 to it clears it. If a match and a clear fall on the same edge, the flag ends up set.
- R8: Control bit 1 is the polarity bit. It is written and read at address 2 and selects the leading and trailing levels for matches that occur after the write.
- R9: If both compares match on the same edge, the pin takes the trailing level.
- R10: Address 0 reads the leading value, address 1 reads the staging value, and address 2 reads the control word (bit 6 shows the pin level). Address 3 reads 0. The hidden trailing compare register cannot be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_bus | input | CNT_W | Free-running counter value being compared |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 2 | Register address: 0 leading, 1 staging, 2 control |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from bus_addr |
| pin_out | output | 1 | Output pin level |

## Verification
The bench builds the channel with an 8-bit counter. This lets every leading value from 0 to 255 be armed and run through a full counter wrap, with the polarity alternating from run to run. It also lets leading/trailing pairs, including equal values and trailing-before-leading orderings, run through two complete wraps, so every one-shot is seen not to retrigger. The expected pin level at each edge is computed from the start count, the match values and the polarity. Directed sequences cover the staging-register holdover, the commit strobe and the flag set-beats-clear edge.

// File: rtl/oscc_pkg.sv
package oscc_pkg;

    localparam int unsigned REG_ADDR_W = 2;
    localparam int unsigned CMP_N      = 2;
    localparam int unsigned CMP_LEAD   = 0;
    localparam int unsigned CMP_TRAIL  = 1;
    localparam int unsigned CTL_W      = 8;

    // control word bit positions
    localparam int unsigned CTL_FLAG   = 0;
    localparam int unsigned CTL_POL    = 1;
    localparam int unsigned CTL_COMMIT = 2;
    localparam int unsigned CTL_ARM_L  = 4;
    localparam int unsigned CTL_ARM_T  = 5;
    localparam int unsigned CTL_PIN    = 6;
    localparam int unsigned CTL_PEND   = 7;

    typedef enum logic [REG_ADDR_W-1:0] {
        RSEL_LEAD  = 2'd0,
        RSEL_STAGE = 2'd1,
        RSEL_CTL   = 2'd2,
        RSEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic pend;
        logic pin;
        logic arm_t;
        logic arm_l;
        logic pol;
        logic flag;
    } ctl_view_t;

    function automatic logic lead_level(input logic pol);
        return ~pol;
    endfunction

    function automatic logic trail_level(input logic pol);
        return pol;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_pack(input ctl_view_t v);
        logic [CTL_W-1:0] r;
        r             = '0;
        r[CTL_FLAG]   = v.flag;
        r[CTL_POL]    = v.pol;
        r[CTL_ARM_L]  = v.arm_l;
        r[CTL_ARM_T]  = v.arm_t;
        r[CTL_PIN]    = v.pin;
        r[CTL_PEND]   = v.pend;
        return r;
    endfunction

endpackage

// File: rtl/oscc_match.sv
module oscc_match #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic [W-1:0] cnt,
    output logic         hit,
    output logic         armed
);

    logic [W-1:0] val_q;
    logic         armed_q;

    assign hit   = armed_q && (cnt == val_q);
    assign armed = armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q   <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            val_q   <= val;
            armed_q <= 1'b1;
        end else if (hit) begin
            armed_q <= 1'b0;
        end
    end

endmodule

// File: rtl/oscc_pin.sv
module oscc_pin
    import oscc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pol,
    input  logic hit_lead,
    input  logic hit_trail,
    output logic pin
);

    logic pin_q;

    assign pin = pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else if (hit_trail) begin
            pin_q <= trail_level(pol);
        end else if (hit_lead) begin
            pin_q <= lead_level(pol);
        end
    end

endmodule

// File: rtl/oscc_regs.sv
module oscc_regs
    import oscc_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_sel,
    input  logic                         bus_we,
    input  logic [REG_ADDR_W-1:0]        bus_addr,
    input  logic [DW-1:0]                bus_wdata,
    output logic [DW-1:0]                bus_rdata,
    input  logic [CMP_N-1:0]             hit,
    input  logic [CMP_N-1:0]             armed,
    input  logic                         pin_lvl,
    output logic [CMP_N-1:0]             load_req,
    output logic [CMP_N-1:0][DW-1:0]     load_val,
    output logic                         pol,
    output logic                         flag
);

    reg_sel_e  sel;
    logic      wr;
    logic      wr_lead;
    logic      wr_stage;
    logic      wr_ctl;
    logic      commit_t;
    logic      clr_flag;
    logic      xfer_t;
    logic [DW-1:0] lead_q;
    logic [DW-1:0] stage_q;
    logic      pend_q;
    logic      pol_q;
    logic      flag_q;
    ctl_view_t view;

    assign sel      = reg_sel_e'(bus_addr);
    assign wr       = bus_sel && bus_we;
    assign wr_lead  = wr && (sel == RSEL_LEAD);
    assign wr_stage = wr && (sel == RSEL_STAGE);
    assign wr_ctl   = wr && (sel == RSEL_CTL);
    assign commit_t = wr_ctl && bus_wdata[CTL_COMMIT];
    assign clr_flag = wr_ctl && bus_wdata[CTL_FLAG];
    assign xfer_t   = (wr_lead && pend_q) || commit_t;

    assign load_req[CMP_LEAD]  = wr_lead;
    assign load_val[CMP_LEAD]  = bus_wdata;
    assign load_req[CMP_TRAIL] = xfer_t;
    assign load_val[CMP_TRAIL] = stage_q;

    assign pol  = pol_q;
    assign flag = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lead_q  <= '0;
            stage_q <= '0;
            pend_q  <= 1'b0;
            pol_q   <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (wr_lead) begin
                lead_q <= bus_wdata;
            end
            if (wr_stage) begin
                stage_q <= bus_wdata;
                pend_q  <= 1'b1;
            end else if (xfer_t) begin
                pend_q  <= 1'b0;
            end
            if (wr_ctl) begin
                pol_q <= bus_wdata[CTL_POL];
            end
            if (|hit) begin
                flag_q <= 1'b1;
            end else if (clr_flag) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        view       = '0;
        view.flag  = flag_q;
        view.pol   = pol_q;
        view.arm_l = armed[CMP_LEAD];
        view.arm_t = armed[CMP_TRAIL];
        view.pin   = pin_lvl;
        view.pend  = pend_q;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            RSEL_LEAD:  bus_rdata = lead_q;
            RSEL_STAGE: bus_rdata = stage_q;
            RSEL_CTL:   bus_rdata[CTL_W-1:0] = ctl_pack(view);
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/oneshot_cmp_chan.sv
module oneshot_cmp_chan
    import oscc_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CNT_W-1:0]      cnt_bus,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]      bus_wdata,
    output logic [CNT_W-1:0]      bus_rdata,
    output logic                  pin_out
);

    logic [CMP_N-1:0]            load_req;
    logic [CMP_N-1:0][CNT_W-1:0] load_val;
    logic [CMP_N-1:0]            hit;
    logic [CMP_N-1:0]            armed;
    logic                        pol;
    logic                        flag;

    oscc_regs #(.DW(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hit       (hit),
        .armed     (armed),
        .pin_lvl   (pin_out),
        .load_req  (load_req),
        .load_val  (load_val),
        .pol       (pol),
        .flag      (flag)
    );

    for (genvar g = 0; g < CMP_N; g++) begin : g_cmp
        oscc_match #(.W(CNT_W)) u_match (
            .clk   (clk),
            .rst   (rst),
            .load  (load_req[g]),
            .val   (load_val[g]),
            .cnt   (cnt_bus),
            .hit   (hit[g]),
            .armed (armed[g])
        );
    end

    oscc_pin u_pin (
        .clk       (clk),
        .rst       (rst),
        .pol       (pol),
        .hit_lead  (hit[CMP_LEAD]),
        .hit_trail (hit[CMP_TRAIL]),
        .pin       (pin_out)
    );

endmodule

// File: rtl/oscc_chk.sv
module oscc_chk
    import oscc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr_wr,
    input logic [CMP_N-1:0] hit,
    input logic [CMP_N-1:0] load_req,
    input logic [CMP_N-1:0] armed,
    input logic             pol,
    input logic             flag,
    input logic             pin
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pin && armed == '0 && !flag && !pol));

    // R2
    lead_level_chk: assert property (@(posedge clk) disable iff (rst)
        (hit[CMP_LEAD] && !hit[CMP_TRAIL]) |=> (pin == ~$past(pol)));

    // R3
    trail_level_chk: assert property (@(posedge clk) disable iff (rst)
        hit[CMP_TRAIL] |=> (pin == $past(pol)));

    // R9
    both_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (hit[CMP_LEAD] && hit[CMP_TRAIL]) |=> (pin == $past(pol)));

    // R4
    lead_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (hit[CMP_LEAD] && !load_req[CMP_LEAD]) |=> !armed[CMP_LEAD]);

    // R4
    trail_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (hit[CMP_TRAIL] && !load_req[CMP_TRAIL]) |=> !armed[CMP_TRAIL]);

    // R4
    pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hit == '0) |=> $stable(pin));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> flag);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && hit == '0) |=> !flag);

endmodule

bind oneshot_cmp_chan oscc_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .clr_wr   (bus_sel && bus_we && (bus_addr == oscc_pkg::RSEL_CTL) && bus_wdata[oscc_pkg::CTL_FLAG]),
    .hit      (hit),
    .load_req (load_req),
    .armed    (armed),
    .pol      (pol),
    .flag     (flag),
    .pin      (pin_out)
);

// File: tb/oneshot_cmp_chan_tb_top.sv
`timescale 1ns/1ps
module oneshot_cmp_chan_tb_top;

    localparam int CW = 8;
    localparam int M  = 1 << CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cnt = '0;
    logic          run = 1'b0;
    logic          ld  = 1'b0;
    logic [CW-1:0] ld_v = '0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;
    logic          pin_out;

    int  n_chk = 0;
    int  n_err = 0;
    logic m_pin = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (ld) cnt <= ld_v;
        else if (run) cnt <= cnt + 1'b1;
    end

    oneshot_cmp_chan #(.CNT_W(CW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cnt_bus   (cnt),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = CW'(d);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic set_cnt(input int v);
        @(negedge clk);
        ld = 1'b1; ld_v = CW'(v);
        @(negedge clk);
        ld = 1'b0;
    endtask

    function automatic int ctlw(input bit pol, input bit clr, input bit commit);
        return (int'(commit) << 2) | (int'(pol) << 1) | int'(clr);
    endfunction

    // must be entered right after a negedge with the bus idle
    task automatic run_chk(input int n, input int s, input bit use_a, input int a,
                           input bit use_b, input int b, input logic pol, input string tag);
        bit ea;
        bit eb;
        ea = use_a;
        eb = use_b;
        run = 1'b1;
        for (int k = 0; k < n; k++) begin
            int  c;
            bit  ha;
            bit  hb;
            c  = (s + k) % M;
            ha = ea && (c == a);
            hb = eb && (c == b);
            @(posedge clk);
            if (hb) m_pin = pol;
            else if (ha) m_pin = ~pol;
            if (ha) ea = 1'b0;
            if (hb) eb = 1'b0;
            @(negedge clk);
            if (k == n - 1) run = 1'b0;
            check(pin_out === m_pin, tag, int'(pin_out), int'(m_pin));
        end
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int v;
        bit pol;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(pin_out === 1'b0, "R1 pin after reset", int'(pin_out), 0);
        rd(2'd2, v);
        check(v == 0, "R1 control after reset", v, 0);
        rd(2'd0, v);
        check(v == 0, "R1 leading value after reset", v, 0);

        // R10 / R5 readback of a first pair
        set_cnt(5);
        wr(2'd1, 77);
        rd(2'd1, v);
        check(v == 77, "R10 staging readback", v, 77);
        rd(2'd2, v);
        check(v == 8'h80, "R5 pending after staging write", v, 8'h80);
        wr(2'd0, 33);
        rd(2'd0, v);
        check(v == 33, "R10 leading readback", v, 33);
        rd(2'd2, v);
        check(v == 8'h30, "R5 both armed, pending cleared", v, 8'h30);
        rd(2'd3, v);
        check(v == 0, "R10 address 3 reads zero", v, 0);
        @(negedge clk);
        run_chk(520, 5, 1, 33, 1, 77, 1'b0, "R2 R3 R4 first pair");

        // pair sweep incl. equal values (R9) and trailing-first order
        for (int i = 0; i < 16; i++) begin
            int a;
            int b;
            int s;
            a   = (i * 53 + 7) % M;
            b   = (a + i * 29) % M;
            s   = (i * 11) % M;
            pol = i[0];
            wr(2'd2, ctlw(pol, 1, 0));
            set_cnt(s);
            wr(2'd1, b);
            wr(2'd0, a);
            run_chk(520, s, 1, a, 1, b, pol,
                    (a == b) ? "R9 equal pair" : "R2 R3 R4 R8 pair sweep");
            rd(2'd2, v);
            check(v == ((int'(m_pin) << 6) | (int'(pol) << 1) | 1),
                  "R4 R7 disarmed and flag set after pair", v,
                  (int'(m_pin) << 6) | (int'(pol) << 1) | 1);
        end

        // R6 leading-only sweep over every value, polarity alternating (R8)
        for (int vv = 0; vv < M; vv++) begin
            int s;
            s   = (vv * 7 + 3) % M;
            pol = vv[0];
            wr(2'd2, ctlw(pol, 1, 0));
            set_cnt(s);
            wr(2'd0, vv);
            run_chk(258, s, 1, vv, 0, 0, pol, "R6 R8 leading-only sweep");
        end

        // R5 staging write after transfer does not disturb armed trailing compare
        pol = 1'b0;
        wr(2'd2, ctlw(pol, 1, 0));
        set_cnt(0);
        wr(2'd1, 40);
        wr(2'd0, 20);
        wr(2'd1, 90);
        run_chk(300, 0, 1, 20, 1, 40, pol, "R5 held trailing value");
        rd(2'd1, v);
        check(v == 90, "R5 staging keeps new value", v, 90);
        rd(2'd2, v);
        check(((v >> 7) & 1) == 1, "R5 pending after late staging write", (v >> 7) & 1, 1);

        // R5 commit strobe arms trailing only; polarity flip makes pin lead
        pol = 1'b1;
        set_cnt(0);
        wr(2'd2, ctlw(pol, 1, 1));
        rd(2'd2, v);
        check(v == ((int'(m_pin) << 6) | 8'h20 | 2), "R5 commit arms trailing only", v,
              (int'(m_pin) << 6) | 8'h20 | 2);
        @(negedge clk);
        run_chk(300, 0, 0, 0, 1, 90, pol, "R5 R3 commit-only trailing edge");

        // R7 set wins over same-edge clear
        set_cnt(200);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'd200;
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = CW'(ctlw(pol, 1, 0));
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        rd(2'd2, v);
        check((v & 1) == 1, "R7 set beats clear", v & 1, 1);
        check(pin_out === ~pol, "R2 leading level on immediate match", int'(pin_out), int'(~pol));
        wr(2'd2, ctlw(pol, 1, 0));
        rd(2'd2, v);
        check((v & 1) == 0, "R7 write-one clears flag", v & 1, 0);

        summary();
        $finish;
    end

endmodule